// File: doc/BRIEF.md
# Data Address Translator with Fault Status

This block turns the virtual address of a data load or store into a physical address. For each request it does four things. It picks the privilege mode that governs the access. It applies the direct-mapped kernel superpage window. It takes the hit, frame number and permission bits that an external TLB returns for the same address in the same cycle. It then enforces the read and write enables for that mode and the entry's fault-on-read and fault-on-write bits. Each response carries a physical address, an uncacheable flag and a fault code.

Requests arrive on a valid/ready channel and leave on another. A single output register holds the response until it is taken. When a request is accepted and faults, three registers record the fault: the faulting address, a packed status word and a formatted page-table address. They then lock until software reads the address register, which it signals with a one-cycle read strobe.

Top module: `data_xlate`

## Requirements
- R1: `req_ready` equals `!rsp_valid || rsp_ready`. The response to a request accepted at a clock edge is valid after that edge. While `rsp_valid` is high and `rsp_ready` is low, the response fields do not change.
- R2: The effective mode is `cur_mode` when `priv_mode` is low. When `priv_mode` is high it is `alt_mode` for a request flagged `req_alt`, and kernel (0) otherwise. Mode encoding: 0 kernel, 1 executive, 2 supervisor, 3 user. Bit m of `tlb_rd_en` and of `tlb_wr_en` grants read and write in mode m.
- R3: An address whose bits 63:42 are not all equal gives code 2 (data fault). Its cause flags are access-violation and bad-address, plus write for a store.
- R4: When `sp_en[1]` is set and VA bits 42:41 equal 2'b10, the access is a superpage access. If `cur_mode` is kernel, the TLB is ignored, the result is code 0 and PA = VA[39:0]. Otherwise the result is code 1 (access violation) with the access-violation flag, plus write for a store.
- R5: A canonical, non-superpage access that misses in the TLB gives code 4 (double miss) when `req_pte` is set and code 3 (miss) otherwise. Its cause flags are miss, plus write for a store.
- R6: A store that hits without write enable for the effective mode gives code 2 with write and access-violation set, and fault-on-write copied from the entry. A store with write enable whose entry has fault-on-write set gives code 2 with write and fault-on-write set.
- R7: A load that hits without read enable gives code 1 with access-violation set and fault-on-read copied from the entry. A load with read enable whose entry has fault-on-read set gives code 2 with fault-on-read set.
- R8: On code 0 after a TLB hit, PA = {`tlb_pfn`, VA[12:0]}. `rsp_uncached` equals PA bit 39 when the code is 0. On any fault, PA and `rsp_uncached` are 0.
- R9: The status word is {opcode[5:0], register[4:0], cause[5:0]}, so the opcode sits in bits 16:11 and the register number in bits 10:6. The cause bits are write=0, access-violation=1, fault-on-read=2, fault-on-write=3, miss=4, bad-address=5.
- R10: On a recorded fault, `fault_fva` = `pt_base` OR (VA[42:13] shifted left by 3), and `fault_va` = VA.
- R11: After a recorded fault, later faults leave all three registers unchanged until `va_rd` is pulsed. A fault accepted in the same cycle as `va_rd` is recorded and locks again.
- R12: After reset, `rsp_valid` is low, all three fault registers are zero and the registers are unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_va | input | 64 | Virtual address |
| req_write | input | 1 | 1 for a store |
| req_alt | input | 1 | Use alternate mode when privileged |
| req_pte | input | 1 | Access is a page-table-entry fetch |
| req_opcode | input | 6 | Opcode of the instruction |
| req_reg | input | 5 | Destination register number |
| priv_mode | input | 1 | Processor is in privileged mode |
| cur_mode | input | 2 | Current mode register |
| alt_mode | input | 2 | Alternate mode register |
| sp_en | input | 2 | Superpage enable bits (bit 1 used) |
| pt_base | input | 64 | Page-table base for the formatted address |
| tlb_hit | input | 1 | External TLB hit |
| tlb_pfn | input | 27 | Page frame number |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fonr | input | 1 | Entry fault-on-read |
| tlb_fonw | input | 1 | Entry fault-on-write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_pa | output | 40 | Physical address |
| rsp_uncached | output | 1 | Uncacheable access |
| rsp_code | output | 3 | 0 ok, 1 access violation, 2 data fault, 3 miss, 4 double miss |
| va_rd | input | 1 | Read strobe of the fault address register |
| fault_va | output | 64 | Recorded faulting address |
| fault_stat | output | 17 | Recorded status word |
| fault_fva | output | 64 | Recorded formatted address |

## Verification
Two functions can fall in the same cycle: a new fault being recorded, and the software read that releases the lock. The bench first records one fault and sends a second fault with no read, which must leave the registers on the first. It then locks the registers again and sends a faulting request with `va_rd` held high in the same cycle. The registers must then hold the new request's address, status word and formatted address, and a later fault without a read must not overwrite them. A stalled response channel is also overlapped with queued requests, so that back-pressure and the response order are judged against the scoreboard queue.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  localparam int OPC_W   = 6;
  localparam int REGN_W  = 5;
  localparam int CAUSE_W = 6;
  localparam int NMODE   = 4;

  localparam int CB_WR    = 0;
  localparam int CB_ACV   = 1;
  localparam int CB_FONR  = 2;
  localparam int CB_FONW  = 3;
  localparam int CB_MISS  = 4;
  localparam int CB_BADVA = 5;

  typedef enum logic [2:0] {
    XC_OK    = 3'd0,
    XC_ACV   = 3'd1,
    XC_FAULT = 3'd2,
    XC_MISS  = 3'd3,
    XC_DMISS = 3'd4
  } xcode_e;

  typedef enum logic [1:0] {
    PM_KERNEL = 2'd0,
    PM_EXEC   = 2'd1,
    PM_SUPER  = 2'd2,
    PM_USER   = 2'd3
  } pmode_e;
endpackage

// File: rtl/dxl_mode_sel.sv
module dxl_mode_sel
  import dxl_pkg::*;
(
  input  logic       priv_mode,
  input  logic       use_alt,
  input  logic [1:0] cur_mode,
  input  logic [1:0] alt_mode,
  output pmode_e     eff_mode
);
  always_comb begin
    if (!priv_mode)   eff_mode = pmode_e'(cur_mode);
    else if (use_alt) eff_mode = pmode_e'(alt_mode);
    else              eff_mode = PM_KERNEL;
  end
endmodule

// File: rtl/dxl_classify.sv
module dxl_classify
  import dxl_pkg::*;
#(
  parameter int AW      = 64,
  parameter int VA_W    = 43,
  parameter int PA_W    = 40,
  parameter int PG_BITS = 13,
  localparam int PFN_W  = PA_W - PG_BITS
) (
  input  logic [AW-1:0]      va,
  input  logic               write,
  input  logic               pte_fetch,
  input  pmode_e             eff_mode,
  input  logic [1:0]         cur_mode,
  input  logic [1:0]         sp_en,
  input  logic               tlb_hit,
  input  logic [PFN_W-1:0]   tlb_pfn,
  input  logic [NMODE-1:0]   tlb_rd_en,
  input  logic [NMODE-1:0]   tlb_wr_en,
  input  logic               tlb_fonr,
  input  logic               tlb_fonw,
  output logic [PA_W-1:0]    pa,
  output logic               uncached,
  output xcode_e             code,
  output logic [CAUSE_W-1:0] cause
);
  logic canon, spage, rd_ok, wr_ok;
  logic [PA_W-1:0] pa_raw;
  logic unused_va_bits;

  assign canon = (&va[AW-1:VA_W-1]) | ~(|va[AW-1:VA_W-1]);
  assign spage = sp_en[1] && (va[VA_W-1:VA_W-2] == 2'b10);
  assign rd_ok = tlb_rd_en[eff_mode];
  assign wr_ok = tlb_wr_en[eff_mode];
  assign unused_va_bits = ^{va[VA_W-3:PA_W], sp_en[0]};

  always_comb begin
    code   = XC_OK;
    cause  = '0;
    pa_raw = '0;
    if (!canon) begin
      code            = XC_FAULT;
      cause[CB_WR]    = write;
      cause[CB_ACV]   = 1'b1;
      cause[CB_BADVA] = 1'b1;
    end else if (spage) begin
      if (cur_mode != PM_KERNEL) begin
        code          = XC_ACV;
        cause[CB_WR]  = write;
        cause[CB_ACV] = 1'b1;
      end else begin
        pa_raw = va[PA_W-1:0];
      end
    end else if (!tlb_hit) begin
      code           = pte_fetch ? XC_DMISS : XC_MISS;
      cause[CB_WR]   = write;
      cause[CB_MISS] = 1'b1;
    end else begin
      pa_raw = {tlb_pfn, va[PG_BITS-1:0]};
      if (write) begin
        if (!wr_ok) begin
          code           = XC_FAULT;
          cause[CB_WR]   = 1'b1;
          cause[CB_ACV]  = 1'b1;
          cause[CB_FONW] = tlb_fonw;
        end else if (tlb_fonw) begin
          code           = XC_FAULT;
          cause[CB_WR]   = 1'b1;
          cause[CB_FONW] = 1'b1;
        end
      end else begin
        if (!rd_ok) begin
          code           = XC_ACV;
          cause[CB_ACV]  = 1'b1;
          cause[CB_FONR] = tlb_fonr;
        end else if (tlb_fonr) begin
          code           = XC_FAULT;
          cause[CB_FONR] = 1'b1;
        end
      end
    end
    pa       = (code == XC_OK) ? pa_raw : '0;
    uncached = (code == XC_OK) & pa_raw[PA_W-1];
  end
endmodule

// File: rtl/dxl_fault_regs.sv
module dxl_fault_regs
  import dxl_pkg::*;
#(
  parameter int AW      = 64,
  parameter int VA_W    = 43,
  parameter int PG_BITS = 13,
  localparam int ST_W   = OPC_W + REGN_W + CAUSE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_req,
  input  logic               va_rd,
  input  logic [AW-1:0]      va,
  input  logic [OPC_W-1:0]   opcode,
  input  logic [REGN_W-1:0]  regn,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [AW-1:0]      pt_base,
  output logic [AW-1:0]      fault_va,
  output logic [ST_W-1:0]    fault_stat,
  output logic [AW-1:0]      fault_fva
);
  logic lock_q, cap;

  assign cap = cap_req && (!lock_q || va_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      fault_va   <= '0;
      fault_stat <= '0;
      fault_fva  <= '0;
    end else begin
      if (cap) begin
        lock_q     <= 1'b1;
        fault_va   <= va;
        fault_stat <= {opcode, regn, cause};
        fault_fva  <= pt_base | (AW'(va[VA_W-1:PG_BITS]) << 3);
      end else if (va_rd) begin
        lock_q <= 1'b0;
      end
    end
  end

  assert_lock_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !va_rd) |=> ($stable(fault_va) && $stable(fault_stat) && $stable(fault_fva)));

  assert_stat_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (fault_stat[ST_W-1:ST_W-OPC_W] == $past(opcode)) &&
            (fault_stat[CAUSE_W+REGN_W-1:CAUSE_W] == $past(regn)));

  assert_rd_unlock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_req && va_rd) |=> (fault_va == $past(va)));
endmodule

// File: rtl/data_xlate.sv
module data_xlate
  import dxl_pkg::*;
#(
  parameter int AW      = 64,
  parameter int VA_W    = 43,
  parameter int PA_W    = 40,
  parameter int PG_BITS = 13,
  localparam int PFN_W  = PA_W - PG_BITS,
  localparam int ST_W   = OPC_W + REGN_W + CAUSE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AW-1:0]      req_va,
  input  logic               req_write,
  input  logic               req_alt,
  input  logic               req_pte,
  input  logic [OPC_W-1:0]   req_opcode,
  input  logic [REGN_W-1:0]  req_reg,
  input  logic               priv_mode,
  input  logic [1:0]         cur_mode,
  input  logic [1:0]         alt_mode,
  input  logic [1:0]         sp_en,
  input  logic [AW-1:0]      pt_base,
  input  logic               tlb_hit,
  input  logic [PFN_W-1:0]   tlb_pfn,
  input  logic [NMODE-1:0]   tlb_rd_en,
  input  logic [NMODE-1:0]   tlb_wr_en,
  input  logic               tlb_fonr,
  input  logic               tlb_fonw,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_pa,
  output logic               rsp_uncached,
  output logic [2:0]         rsp_code,
  input  logic               va_rd,
  output logic [AW-1:0]      fault_va,
  output logic [ST_W-1:0]    fault_stat,
  output logic [AW-1:0]      fault_fva
);
  pmode_e             eff_mode;
  logic [PA_W-1:0]    c_pa;
  logic               c_unc;
  xcode_e             c_code;
  logic [CAUSE_W-1:0] c_cause;
  logic               accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  dxl_mode_sel u_mode (
    .priv_mode (priv_mode),
    .use_alt   (req_alt),
    .cur_mode  (cur_mode),
    .alt_mode  (alt_mode),
    .eff_mode  (eff_mode)
  );

  dxl_classify #(.AW(AW), .VA_W(VA_W), .PA_W(PA_W), .PG_BITS(PG_BITS)) u_cls (
    .va        (req_va),
    .write     (req_write),
    .pte_fetch (req_pte),
    .eff_mode  (eff_mode),
    .cur_mode  (cur_mode),
    .sp_en     (sp_en),
    .tlb_hit   (tlb_hit),
    .tlb_pfn   (tlb_pfn),
    .tlb_rd_en (tlb_rd_en),
    .tlb_wr_en (tlb_wr_en),
    .tlb_fonr  (tlb_fonr),
    .tlb_fonw  (tlb_fonw),
    .pa        (c_pa),
    .uncached  (c_unc),
    .code      (c_code),
    .cause     (c_cause)
  );

  dxl_fault_regs #(.AW(AW), .VA_W(VA_W), .PG_BITS(PG_BITS)) u_freg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_req    (accept && (c_code != XC_OK)),
    .va_rd      (va_rd),
    .va         (req_va),
    .opcode     (req_opcode),
    .regn       (req_reg),
    .cause      (c_cause),
    .pt_base    (pt_base),
    .fault_va   (fault_va),
    .fault_stat (fault_stat),
    .fault_fva  (fault_fva)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_pa       <= '0;
      rsp_uncached <= 1'b0;
      rsp_code     <= XC_OK;
    end else begin
      if (accept) begin
        rsp_valid    <= 1'b1;
        rsp_pa       <= c_pa;
        rsp_uncached <= c_unc;
        rsp_code     <= c_code;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assert_rsp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_code)));

  assert_kseg_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (&req_va[AW-1:VA_W-1]) && !req_va[VA_W-2] && sp_en[1] && (cur_mode == 2'd0))
      |=> (rsp_code == 3'd0) && (rsp_pa == $past(req_va[PA_W-1:0])));

  assert_miss_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !tlb_hit && (req_va[AW-1:VA_W-1] == '0))
      |=> (rsp_code == 3'd3 || rsp_code == 3'd4));
endmodule

// File: tb/tb_data_xlate.sv
module tb_data_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_alt = 0, req_pte = 0;
  logic [63:0] req_va = '0;
  logic [5:0] req_opcode = '0;
  logic [4:0] req_reg = '0;
  logic priv_mode = 0;
  logic [1:0] cur_mode = 0, alt_mode = 0, sp_en = 0;
  logic [63:0] pt_base = 64'h0000_0100_0000_0000;
  logic tlb_hit = 0, tlb_fonr = 0, tlb_fonw = 0;
  logic [26:0] tlb_pfn = '0;
  logic [3:0] tlb_rd_en = '0, tlb_wr_en = '0;
  logic rsp_ready = 1, va_rd = 0;
  logic req_ready, rsp_valid, rsp_uncached;
  logic [39:0] rsp_pa;
  logic [2:0] rsp_code;
  logic [63:0] fault_va, fault_fva;
  logic [16:0] fault_stat;

  data_xlate dut (.*);

  int checks = 0, errors = 0, nsent = 0;
  bit finished = 0;
  logic [43:0] expq[$];
  logic [63:0] m_va = '0, m_fva = '0;
  logic [16:0] m_stat = '0;
  bit m_lk = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [63:0] va, input bit wr, input bit hit,
                       input logic [26:0] pfn, input logic [3:0] rde, input logic [3:0] wre,
                       input bit fr, input bit fw,
                       output logic [2:0] code, output logic [5:0] cf, output logic [39:0] pa);
    logic [1:0] m;
    bit canon;
    m = !priv_mode ? cur_mode : (req_alt ? alt_mode : 2'd0);
    canon = (va[63:42] == '0) || (va[63:42] == '1);
    code = 0; cf = 0; pa = 0;
    if (!canon) begin code = 2; cf = {1'b1, 3'b0, 1'b1, wr}; end
    else if (sp_en[1] && va[42:41] == 2'b10) begin
      if (cur_mode != 0) begin code = 1; cf = {4'b0, 1'b1, wr}; end
      else pa = va[39:0];
    end else if (!hit) begin code = req_pte ? 3'd4 : 3'd3; cf = {2'b01, 3'b0, wr}; end
    else begin
      pa = {pfn, va[12:0]};
      if (wr) begin
        if (!wre[m]) begin code = 2; cf = {2'b00, fw, 1'b0, 2'b11}; end
        else if (fw) begin code = 2; cf = 6'b001001; end
      end else begin
        if (!rde[m]) begin code = 1; cf = {3'b000, fr, 2'b10}; end
        else if (fr) begin code = 2; cf = 6'b000100; end
      end
      if (code != 0) pa = 0;
    end
  endtask

  task automatic send(input logic [63:0] va, input bit wr, input bit hit, input logic [26:0] pfn,
                      input logic [3:0] rde, input logic [3:0] wre, input bit fr, input bit fw,
                      input bit rd);
    logic [2:0] code; logic [5:0] cf; logic [39:0] pa; bit cap;
    req_va = va; req_write = wr; tlb_hit = hit; tlb_pfn = pfn; tlb_rd_en = rde;
    tlb_wr_en = wre; tlb_fonr = fr; tlb_fonw = fw; va_rd = rd;
    req_opcode = 6'(nsent * 7 + 3); req_reg = 5'(nsent * 3 + 1);
    req_valid = 1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    model(va, wr, hit, pfn, rde, wre, fr, fw, code, cf, pa);
    expq.push_back({code, pa[39], pa});
    cap = (code != 0) && (!m_lk || rd);
    if (cap) begin
      m_va = va; m_stat = {req_opcode, req_reg, cf};
      m_fva = pt_base | (64'(va[42:13]) << 3); m_lk = 1;
    end else if (rd) m_lk = 0;
    @(negedge clk);
    req_valid = 0; va_rd = 0; nsent++;
  endtask

  task automatic read_va();
    va_rd = 1; m_lk = 0;
    @(negedge clk);
    va_rd = 0;
  endtask

  task automatic check_fregs(input string tag);
    repeat (3) @(negedge clk);
    #3;
    chk(fault_va == m_va, {tag, " fault_va"}, fault_va, m_va);
    chk(fault_stat == m_stat, {tag, " fault_stat"}, 64'(fault_stat), 64'(m_stat));
    chk(fault_fva == m_fva, {tag, " fault_fva"}, fault_fva, m_fva);
  endtask

  // monitor: compare each completed response against the scoreboard
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (expq.size() == 0) chk(0, "R1 unexpected response", 64'(rsp_code), 0);
        else begin
          logic [43:0] e;
          e = expq.pop_front();
          chk({rsp_code, rsp_uncached, rsp_pa} == e, "R1-order/R3..R8 response",
              64'({rsp_code, rsp_uncached, rsp_pa}), 64'(e));
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    chk(0, "watchdog expired", 0, 1);
    if (!finished) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [63:0] LOWVA = 64'h0000_0000_1234_5678;
  localparam logic [63:0] SPVA  = 64'hFFFF_FC80_0000_2000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #3;
    // R12 reset state
    chk(rsp_valid == 0, "R12 rsp_valid", 64'(rsp_valid), 0);
    chk(req_ready == 1, "R12 req_ready", 64'(req_ready), 1);
    chk(fault_va == 0 && fault_stat == 0 && fault_fva == 0, "R12 fault regs", fault_va, 0);
    @(negedge clk);

    // R8 hit, cacheable then uncacheable
    send(LOWVA, 0, 1, 27'h0012345, 4'hF, 4'hF, 0, 0, 0);
    send(LOWVA, 1, 1, 27'h4000001, 4'hF, 4'hF, 0, 0, 0);

    // R2 user-mode permissions; R7 load access violation with fault-on-read
    cur_mode = 3;
    send(LOWVA, 0, 1, 27'h0000AB, 4'b1000, 4'h0, 0, 0, 0);
    send(LOWVA, 0, 1, 27'h0000AB, 4'b0111, 4'h0, 1, 0, 0);
    check_fregs("R9/R10 first fault");
    // R11 second fault without read must not overwrite
    send(64'h0000_0000_0ABC_0000, 1, 0, 0, 0, 0, 0, 0, 0);
    check_fregs("R11 locked");
    read_va();
    // R5 miss codes after unlock
    cur_mode = 0;
    send(64'h0000_0000_0ABC_0000, 1, 0, 0, 0, 0, 0, 0, 0);
    check_fregs("R5/R11 recorded after read");
    req_pte = 1;
    send(64'h0000_0000_0DEF_2000, 0, 0, 0, 0, 0, 0, 0, 0);
    req_pte = 0;
    // R11 fault in the same cycle as the read strobe is recorded
    send(64'h0000_0001_2345_6000, 0, 1, 27'h11, 4'h0, 4'h0, 0, 0, 1);
    check_fregs("R11 same-cycle read and fault");
    send(LOWVA, 1, 1, 27'h22, 4'hF, 4'h0, 0, 1, 0);
    check_fregs("R11 relocked");
    read_va();

    // R2 privileged: alternate mode and kernel default
    priv_mode = 1; cur_mode = 3; alt_mode = 3; req_alt = 1;
    send(LOWVA, 0, 1, 27'h33, 4'b1000, 4'h0, 0, 0, 0);
    send(LOWVA, 0, 1, 27'h33, 4'b0001, 4'h0, 0, 0, 0);
    req_alt = 0;
    send(LOWVA, 0, 1, 27'h34, 4'b0001, 4'h0, 0, 0, 0);
    send(LOWVA, 0, 1, 27'h34, 4'b1000, 4'h0, 0, 0, 0);
    priv_mode = 0; cur_mode = 0;
    read_va();

    // R3 non-canonical store
    send(64'h0001_0000_0000_0000, 1, 1, 27'h1, 4'hF, 4'hF, 0, 0, 0);
    check_fregs("R3 bad address status");
    read_va();

    // R4 superpage: kernel bypass with miss, user violation, bit 0 only
    sp_en = 2'b10;
    send(SPVA, 0, 0, 0, 0, 0, 0, 0, 0);
    cur_mode = 2;
    send(SPVA, 1, 1, 27'h5, 4'hF, 4'hF, 0, 0, 0);
    check_fregs("R4 superpage violation status");
    read_va();
    cur_mode = 0; sp_en = 2'b01;
    send(SPVA, 0, 0, 0, 0, 0, 0, 0, 0);
    sp_en = 0;

    // R6 store permission and fault-on-write; R7 fault-on-read
    send(LOWVA, 1, 1, 27'h44, 4'hF, 4'b1110, 0, 1, 0);
    check_fregs("R6 store violation status");
    read_va();
    send(LOWVA, 1, 1, 27'h44, 4'hF, 4'hF, 0, 1, 0);
    check_fregs("R6 fault-on-write status");
    read_va();
    send(LOWVA, 0, 1, 27'h44, 4'hF, 4'hF, 1, 0, 0);
    check_fregs("R7 fault-on-read status");
    read_va();

    // R1 back-pressure: stall the response channel across queued requests
    rsp_ready = 0;
    fork
      begin
        send(LOWVA, 0, 1, 27'h50, 4'hF, 4'hF, 0, 0, 0);
        send(LOWVA, 0, 1, 27'h51, 4'hF, 4'hF, 0, 0, 0);
        send(LOWVA, 0, 1, 27'h52, 4'hF, 4'hF, 0, 0, 0);
      end
      begin
        repeat (3) @(negedge clk);
        #2;
        chk(req_ready == 0, "R1 ready low while stalled", 64'(req_ready), 0);
        chk(rsp_pa == {27'h50, 13'h1678}, "R1 held response", 64'(rsp_pa), 64'({27'h50, 13'h1678}));
        @(negedge clk);
        rsp_ready = 1;
      end
    join
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R1 all responses delivered", 64'(expq.size()), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule